// File: doc/BRIEF.md
# Interrupt Request Input Conditioner

This block sits between the external interrupt pins and a CPU interrupt controller, and runs on the bus clock. It brings in one non-maskable interrupt (NMI) pin and four interrupt request pins through synchronizers. It turns NMI edges of a chosen polarity into a pending request. It then presents the request pins in one of two ways: as a debounced 4-bit priority level, or as four separate level requests.

A small control register holds three mode bits. The first decides whether a pending NMI waits for the CPU block bit to clear. The second selects which NMI edge counts. The third selects how the request pins are read. Any write that flips the edge polarity blanks NMI detection for a short window. This keeps the polarity switch itself from being seen as an interrupt. The CPU clears a pending NMI with a one-cycle acknowledge.

Top module: `irq_input_cond`

## Requirements
- R1: After reset the control register reads 0, `nmi_req` is 0, and both `enc_level` and `ind_req` are 0 while the request pins are idle (all ones).
- R2: A write loads bit 25 (NMI no-hold), bit 24 (NMI rising-edge select) and bit 23 (split request mode) of `cfg_wdata`. `cfg_rdata` returns these three bits in the same positions and 0 in every other bit.
- R3: With bit 24 at 0, a falling edge on `nmi_pin` sets the pending NMI, visible on `nmi_req` three clock edges after the pin changes. A rising edge sets nothing.
- R4: With bit 24 at 1, a rising edge on `nmi_pin` sets the pending NMI with the same latency. A falling edge sets nothing.
- R5: A write that changes bit 24 suppresses NMI edge detection on that clock edge and on the following six edges. An edge that falls in this window is lost, and it is not reported when the window ends. A write that leaves bit 24 unchanged starts no window.
- R6: With bit 25 at 0, a pending NMI drives `nmi_req` only while `cpu_block` is 0. It stays pending while `cpu_block` is 1 and appears once `cpu_block` returns to 0.
- R7: With bit 25 at 1, a pending NMI drives `nmi_req` regardless of `cpu_block`.
- R8: A one-cycle `nmi_ack` clears the pending NMI. A qualified edge on the same clock edge as the acknowledge leaves it pending.
- R9: With bit 23 at 0, the request pins are active low. `enc_level` shows the inverted pin value (0 to 15) once the same synchronized value has been sampled on four consecutive edges. This is six clock edges after the pins change.
- R10: With bit 23 at 0, a pin value held for fewer than four samples never reaches `enc_level`.
- R11: With bit 23 at 1, `ind_req[i]` is the inverted, synchronized `req_pin_n[i]`, two clock edges after the pin changes, and `enc_level` is 0. With bit 23 at 0, `ind_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| req_pin_n | input | 4 | Asynchronous active-low request pins |
| cpu_block | input | 1 | CPU block bit (interrupts blocked when 1) |
| nmi_ack | input | 1 | CPU acknowledge of the pending NMI |
| nmi_req | output | 1 | NMI request to the CPU |
| enc_level | output | 4 | Debounced encoded request level (split mode off) |
| ind_req | output | 4 | Independent active-high requests (split mode on) |

## Verification
Each result has a fixed delay from its stimulus. An NMI edge on the pin shows on `nmi_req` after three clock edges: two synchronizer stages plus the pending register. A split-mode request line follows its pin after two edges. An encoded level appears after six edges: two synchronizer stages plus four matching samples. The blanking window after a polarity change covers the write edge and six more. The bench drives inputs on the falling clock edge and counts rising edges before it samples. Where a result is due at edge N, it samples once before edge N to confirm the old value and once after edge N to confirm the new one. `nmi_req` follows `cpu_block` with no clock edge in between.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
   localparam int CFG_NOHOLD_BIT = 25;
   localparam int CFG_RISE_BIT   = 24;
   localparam int CFG_SPLIT_BIT  = 23;

   typedef struct packed {
      logic nmi_nohold;
      logic nmi_rise;
      logic req_split;
   } irq_cfg_t;

   localparam irq_cfg_t CFG_RESET = '{nmi_nohold: 1'b0, nmi_rise: 1'b0, req_split: 1'b0};
endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   initial begin
      if (STAGES < 2) $fatal(1, "irq_sync_chain: STAGES must be at least 2");
      if (WIDTH < 1) $fatal(1, "irq_sync_chain: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/nmi_edge_gate.sv
module nmi_edge_gate #(
   parameter int BLANK_CYCLES = 6,
   parameter logic IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_s,
   input  logic rise_sel,
   input  logic pol_write,
   input  logic nohold,
   input  logic cpu_block,
   input  logic ack,
   output logic nmi_req,
   output logic pending,
   output logic blank_busy
);
   localparam int CW = $clog2(BLANK_CYCLES + 1);

   initial begin
      if (BLANK_CYCLES < 1) $fatal(1, "nmi_edge_gate: BLANK_CYCLES must be at least 1");
   end

   logic          hist_q;
   logic [CW-1:0] blank_q;
   logic          edge_raw;
   logic          edge_hit;

   always_comb begin
      if (rise_sel) edge_raw = nmi_s & ~hist_q;
      else          edge_raw = ~nmi_s & hist_q;
      edge_hit = edge_raw & ~blank_busy & ~pol_write;
   end

   assign blank_busy = (blank_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= IDLE;
         blank_q <= '0;
         pending <= 1'b0;
      end else begin
         hist_q <= nmi_s;
         if (pol_write)       blank_q <= CW'(BLANK_CYCLES);
         else if (blank_busy) blank_q <= blank_q - 1'b1;
         pending <= edge_hit | (pending & ~ack);
      end
   end

   assign nmi_req = pending & (nohold | ~cpu_block);
endmodule

// File: rtl/req_level_filter.sv
module req_level_filter #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 4,
   parameter logic [WIDTH-1:0] IDLE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] level
);
   initial begin
      if (DEPTH < 1) $fatal(1, "req_level_filter: DEPTH must be at least 1");
   end

   generate
      if (DEPTH == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level <= IDLE;
            else        level <= din;
         end
      end else begin : g_count
         localparam int CW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
         logic [WIDTH-1:0] cand_q;
         logic [CW-1:0]    run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cand_q <= IDLE;
               run_q  <= CW'(DEPTH - 1);
               level  <= IDLE;
            end else if (din != cand_q) begin
               cand_q <= din;
               run_q  <= '0;
            end else if (run_q != CW'(DEPTH - 1)) begin
               run_q <= run_q + 1'b1;
               if (run_q == CW'(DEPTH - 2)) level <= cand_q;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_input_cond.sv
module irq_input_cond
   import irq_cond_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NREQ = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH = 4,
   parameter int BLANK_CYCLES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              nmi_pin,
   input  logic [NREQ-1:0]   req_pin_n,
   input  logic              cpu_block,
   input  logic              nmi_ack,
   output logic              nmi_req,
   output logic [NREQ-1:0]   enc_level,
   output logic [NREQ-1:0]   ind_req
);
   initial begin
      if (DATA_W <= CFG_NOHOLD_BIT) $fatal(1, "irq_input_cond: DATA_W too small for mode bits");
      if (NREQ < 1) $fatal(1, "irq_input_cond: NREQ must be at least 1");
   end

   irq_cfg_t        cfg_q;
   logic            pol_write;
   logic            nmi_s;
   logic [NREQ-1:0] req_sync;
   logic [NREQ-1:0] filt_level;
   logic            nmi_pend;
   logic            nmi_blank_busy;

   assign pol_write = cfg_we & (cfg_wdata[CFG_RISE_BIT] != cfg_q.nmi_rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= CFG_RESET;
      else if (cfg_we) begin
         cfg_q.nmi_nohold <= cfg_wdata[CFG_NOHOLD_BIT];
         cfg_q.nmi_rise   <= cfg_wdata[CFG_RISE_BIT];
         cfg_q.req_split  <= cfg_wdata[CFG_SPLIT_BIT];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      cfg_rdata[CFG_NOHOLD_BIT] = cfg_q.nmi_nohold;
      cfg_rdata[CFG_RISE_BIT]   = cfg_q.nmi_rise;
      cfg_rdata[CFG_SPLIT_BIT]  = cfg_q.req_split;
   end

   irq_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
      .clk(clk), .rst_n(rst_n), .din(nmi_pin), .dout(nmi_s)
   );

   irq_sync_chain #(.WIDTH(NREQ), .STAGES(SYNC_STAGES), .RST_VAL({NREQ{1'b1}})) u_req_sync (
      .clk(clk), .rst_n(rst_n), .din(req_pin_n), .dout(req_sync)
   );

   nmi_edge_gate #(.BLANK_CYCLES(BLANK_CYCLES), .IDLE(1'b1)) u_nmi (
      .clk(clk), .rst_n(rst_n), .nmi_s(nmi_s), .rise_sel(cfg_q.nmi_rise),
      .pol_write(pol_write), .nohold(cfg_q.nmi_nohold), .cpu_block(cpu_block),
      .ack(nmi_ack), .nmi_req(nmi_req), .pending(nmi_pend), .blank_busy(nmi_blank_busy)
   );

   req_level_filter #(.WIDTH(NREQ), .DEPTH(FILT_DEPTH), .IDLE({NREQ{1'b1}})) u_filt (
      .clk(clk), .rst_n(rst_n), .din(req_sync), .level(filt_level)
   );

   assign enc_level = cfg_q.req_split ? '0 : ~filt_level;
   assign ind_req   = cfg_q.req_split ? ~req_sync : '0;
endmodule

// File: rtl/irq_input_cond_chk.sv
module irq_input_cond_chk
   import irq_cond_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NREQ = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic              cpu_block,
   input logic              nmi_ack,
   input logic              nmi_req,
   input logic [NREQ-1:0]   enc_level,
   input logic [NREQ-1:0]   ind_req,
   input logic              nmi_pend,
   input logic              nmi_blank_busy,
   input logic [NREQ-1:0]   filt_level,
   input logic [NREQ-1:0]   req_sync
);
   logic [DATA_W-1:0] mode_mask;
   always_comb begin
      mode_mask = '0;
      mode_mask[CFG_NOHOLD_BIT] = 1'b1;
      mode_mask[CFG_RISE_BIT]   = 1'b1;
      mode_mask[CFG_SPLIT_BIT]  = 1'b1;
   end

   p_rdata_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~mode_mask) == '0);

   p_blank_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_blank_busy |=> !$rose(nmi_pend));

   p_held_when_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req && cpu_block) |-> cfg_rdata[CFG_NOHOLD_BIT]);

   p_unblocked_delivers_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend && !cpu_block) |-> nmi_req);

   p_clear_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_pend) |-> $past(nmi_ack));

   p_level_from_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_level) |-> (filt_level == $past(req_sync)));

   p_split_quiet_enc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[CFG_SPLIT_BIT] |-> (enc_level == '0));

   p_enc_quiet_ind_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[CFG_SPLIT_BIT] |-> (ind_req == '0));
endmodule

bind irq_input_cond irq_input_cond_chk #(.DATA_W(DATA_W), .NREQ(NREQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .cpu_block(cpu_block),
   .nmi_ack(nmi_ack), .nmi_req(nmi_req), .enc_level(enc_level), .ind_req(ind_req),
   .nmi_pend(nmi_pend), .nmi_blank_busy(nmi_blank_busy),
   .filt_level(filt_level), .req_sync(req_sync)
);

// File: tb/irq_input_cond_test.sv
`timescale 1ns/1ps
module irq_input_cond_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        nmi_pin = 1'b1;
   logic [3:0]  req_pin_n = 4'hF;
   logic        cpu_block = 1'b0;
   logic        nmi_ack = 1'b0;
   logic        nmi_req;
   logic [3:0]  enc_level;
   logic [3:0]  ind_req;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   irq_input_cond uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .nmi_pin(nmi_pin), .req_pin_n(req_pin_n),
      .cpu_block(cpu_block), .nmi_ack(nmi_ack), .nmi_req(nmi_req),
      .enc_level(enc_level), .ind_req(ind_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      cfg_we = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic ack();
      nmi_ack = 1'b1;
      @(negedge clk);
      nmi_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rdata", cfg_rdata, 32'h0);
      chk("R1 nmi_req", {31'b0, nmi_req}, 32'h0);
      chk("R1 enc_level", {28'b0, enc_level}, 32'h0);
      chk("R1 ind_req", {28'b0, ind_req}, 32'h0);
   endtask

   task automatic t_cfg();
      wr(32'hFFFF_FFFF);
      chk("R2 all ones", cfg_rdata, 32'h0380_0000);
      wr(32'h0100_0000);
      chk("R2 edge bit only", cfg_rdata, 32'h0100_0000);
      wr(32'h0);
      chk("R2 cleared", cfg_rdata, 32'h0);
      tick(10);
      chk("R2 no stray nmi", {31'b0, nmi_req}, 32'h0);
   endtask

   task automatic t_fall();
      nmi_pin = 1'b0;
      tick(2);
      chk("R3 before latency", {31'b0, nmi_req}, 32'h0);
      tick(1);
      chk("R3 falling detected", {31'b0, nmi_req}, 32'h1);
      ack();
      chk("R8 ack clears", {31'b0, nmi_req}, 32'h0);
      nmi_pin = 1'b1;
      tick(5);
      chk("R3 rising ignored", {31'b0, nmi_req}, 32'h0);
   endtask

   task automatic t_rise();
      wr(32'h0100_0000);
      tick(10);
      nmi_pin = 1'b0;
      tick(5);
      chk("R4 falling ignored", {31'b0, nmi_req}, 32'h0);
      nmi_pin = 1'b1;
      tick(2);
      chk("R4 before latency", {31'b0, nmi_req}, 32'h0);
      tick(1);
      chk("R4 rising detected", {31'b0, nmi_req}, 32'h1);
      ack();
   endtask

   task automatic t_blank();
      wr(32'h0);
      nmi_pin = 1'b0;
      tick(10);
      chk("R5 edge in window lost", {31'b0, nmi_req}, 32'h0);
      nmi_pin = 1'b1;
      tick(3);
      nmi_pin = 1'b0;
      tick(3);
      chk("R5 edge after window", {31'b0, nmi_req}, 32'h1);
      ack();
      nmi_pin = 1'b1;
      tick(3);
      wr(32'h0200_0000);
      nmi_pin = 1'b0;
      tick(3);
      chk("R5 same polarity no window", {31'b0, nmi_req}, 32'h1);
      ack();
      wr(32'h0);
      nmi_pin = 1'b1;
      tick(3);
   endtask

   task automatic t_hold();
      cpu_block = 1'b1;
      nmi_pin = 1'b0;
      tick(5);
      chk("R6 held while blocked", {31'b0, nmi_req}, 32'h0);
      cpu_block = 1'b0;
      #1;
      chk("R6 delivered on unblock", {31'b0, nmi_req}, 32'h1);
      tick(1);
      ack();
      chk("R6 cleared", {31'b0, nmi_req}, 32'h0);
      nmi_pin = 1'b1;
      tick(3);
   endtask

   task automatic t_nohold();
      wr(32'h0200_0000);
      cpu_block = 1'b1;
      nmi_pin = 1'b0;
      tick(3);
      chk("R7 passes while blocked", {31'b0, nmi_req}, 32'h1);
      ack();
      chk("R7 ack while blocked", {31'b0, nmi_req}, 32'h0);
      cpu_block = 1'b0;
      wr(32'h0);
      nmi_pin = 1'b1;
      tick(3);
   endtask

   task automatic t_ack_same();
      nmi_pin = 1'b0;
      tick(3);
      chk("R8 pending set", {31'b0, nmi_req}, 32'h1);
      nmi_pin = 1'b1;
      tick(3);
      nmi_pin = 1'b0;
      tick(2);
      ack();
      chk("R8 edge with ack stays", {31'b0, nmi_req}, 32'h1);
      ack();
      chk("R8 second ack clears", {31'b0, nmi_req}, 32'h0);
      nmi_pin = 1'b1;
      tick(3);
   endtask

   task automatic t_enc();
      req_pin_n = 4'b1010;
      tick(5);
      chk("R9 not yet accepted", {28'b0, enc_level}, 32'h0);
      tick(1);
      chk("R9 level 5", {28'b0, enc_level}, 32'h5);
      req_pin_n = 4'b0000;
      tick(6);
      chk("R9 level 15", {28'b0, enc_level}, 32'hF);
      req_pin_n = 4'hF;
      tick(6);
      chk("R9 back to idle", {28'b0, enc_level}, 32'h0);
   endtask

   task automatic t_glitch();
      req_pin_n = 4'b0011;
      tick(3);
      req_pin_n = 4'hF;
      tick(10);
      chk("R10 three samples rejected", {28'b0, enc_level}, 32'h0);
      req_pin_n = 4'b0011;
      tick(4);
      req_pin_n = 4'hF;
      tick(2);
      chk("R10 four samples accepted", {28'b0, enc_level}, 32'hC);
      tick(8);
      chk("R10 idle again", {28'b0, enc_level}, 32'h0);
   endtask

   task automatic t_ind();
      wr(32'h0080_0000);
      req_pin_n = 4'b0110;
      tick(1);
      chk("R11 before latency", {28'b0, ind_req}, 32'h0);
      tick(1);
      chk("R11 ind value", {28'b0, ind_req}, 32'h9);
      chk("R11 enc quiet in split", {28'b0, enc_level}, 32'h0);
      tick(8);
      wr(32'h0);
      chk("R11 ind quiet in encoded", {28'b0, ind_req}, 32'h0);
      chk("R9 filtered level after mode switch", {28'b0, enc_level}, 32'h9);
      req_pin_n = 4'hF;
      tick(8);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_cfg();
      t_fall();
      t_rise();
      t_blank();
      t_hold();
      t_nohold();
      t_ack_same();
      t_enc();
      t_glitch();
      t_ind();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule